// File: doc/BRIEF.md
# Pending Interrupt Priority Arbiter

This block decides, for every processor attached to an interrupt distributor, which interrupt line should be offered next. For each processor it considers only the lines that are both enabled and pending for that processor. Among them it picks the most urgent one, which is the line with the numerically smallest priority value. It then gates that choice with the processor's priority mask and its current running priority.

Each processor gets one registered request output and one registered highest-pending identifier. The identifier reads 1023 when nothing qualifies. Register decoding, acknowledge and end-of-interrupt handling live in neighbouring blocks. Those blocks feed this one with flat enable, pending and priority vectors and with the per-processor control values.

The first 32 interrupt identifiers carry a priority value that is held separately for each processor. All higher identifiers share one priority value across processors. The minimum search is built either as a balanced comparison tree or as a linear scan, chosen by a parameter. Both variants give identical results.

Top module: `irq_prio_arbiter`

## Requirements
- R1: For processor c, `hp_id` reports the identifier of the line with the smallest priority value among lines i where `line_en[c*NUM_IRQ+i]` and `line_pend[c*NUM_IRQ+i]` are both 1. The identifier is either 1023 or below NUM_IRQ.
- R2: When several qualifying lines share the smallest priority value, the lowest identifier among them is reported.
- R3: When no line qualifies for a processor, that processor's identifier is 1023 and its request is low.
- R4: When `dist_en` is 0, or `cpu_if_en[c]` is 0, processor c's request is low and its identifier is 1023. Other processors are unaffected.
- R5: The winner is reported only if its priority is less than or equal to `prio_mask[c*8 +: 8]`. Otherwise the identifier is 1023 and the request is low.
- R6: `cpu_irq[c]` is 1 only when a winner is reported and its priority is strictly below `run_prio[c*9 +: 9]`. The value 0x100 on that field means idle, so any reported winner raises the request.
- R7: For identifiers below 32, the priority used for processor c is `prio_banked[(c*32+i)*8 +: 8]`. For identifiers of 32 and above, it is `prio_shared[(i-32)*8 +: 8]` for every processor.
- R8: Enable and pending bits are evaluated per processor. A line enabled or pending only for processor c never appears at another processor's outputs.
- R9: Outputs are registered. They reflect the inputs present at the previous rising clock edge and do not change between edges. While `rst_n` is low, every request is 0 and every identifier is 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global distributor enable |
| cpu_if_en | input | NUM_CPU | Per-processor interface enable |
| line_en | input | NUM_CPU*NUM_IRQ | Per-processor line enables, bit c*NUM_IRQ+i |
| line_pend | input | NUM_CPU*NUM_IRQ | Per-processor pending bits, bit c*NUM_IRQ+i |
| prio_banked | input | NUM_CPU*32*PRIO_W | Per-processor priorities of identifiers 0 to 31 |
| prio_shared | input | (NUM_IRQ-32)*PRIO_W | Shared priorities of identifiers 32 and up |
| prio_mask | input | NUM_CPU*PRIO_W | Per-processor priority mask |
| run_prio | input | NUM_CPU*(PRIO_W+1) | Per-processor running priority, 0x100 when idle |
| cpu_irq | output | NUM_CPU | Registered interrupt request per processor |
| hp_id | output | NUM_CPU*10 | Registered highest-pending identifier per processor |

## Verification
Every result of this block is due exactly one rising edge after the inputs that produce it. There is one register stage between the inputs and both outputs. The bench therefore changes inputs on the falling edge and compares outputs just after the following rising edge. It also compares once in the half cycle before that edge, to confirm the outputs still hold their previous values. Expected identifiers and requests come from a bench model that repeats the strict-less search, the mask test and the running-priority test from the requirements.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int ID_W     = 10;
   localparam int IDLE_ID  = 1023;
   localparam int BANKED_N = 32;

   // key: MSB set means "no candidate"; lower bits hold the priority value
   function automatic logic key_less(input logic [15:0] a, input logic [15:0] b);
      return a < b;
   endfunction
endpackage

// File: rtl/irq_cand_build.sv
module irq_cand_build
   import irq_arb_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int PRIO_W  = 8,
   localparam int KW     = PRIO_W + 1,
   localparam int SHR_N  = NUM_IRQ - BANKED_N
) (
   input  logic [NUM_IRQ-1:0]         en,
   input  logic [NUM_IRQ-1:0]         pend,
   input  logic [BANKED_N*PRIO_W-1:0] prio_own,
   input  logic [SHR_N*PRIO_W-1:0]    prio_shr,
   output logic [NUM_IRQ*KW-1:0]      keys
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      logic [PRIO_W-1:0] p;
      if (i < BANKED_N) begin : g_own
         assign p = prio_own[i*PRIO_W +: PRIO_W];
      end else begin : g_shr
         assign p = prio_shr[(i-BANKED_N)*PRIO_W +: PRIO_W];
      end
      assign keys[i*KW +: KW] = (en[i] && pend[i]) ? {1'b0, p} : {1'b1, {PRIO_W{1'b0}}};
   end
endmodule

// File: rtl/irq_min_select.sv
module irq_min_select
   import irq_arb_pkg::*;
#(
   parameter int N    = 64,
   parameter int KW   = 9,
   parameter bit TREE = 1'b1,
   localparam int LEAVES = 1 << $clog2(N)
) (
   input  logic [N*KW-1:0]  keys,
   output logic [KW-1:0]    best_key,
   output logic [ID_W-1:0]  best_id
);
   if (TREE) begin : g_tree
      logic [KW-1:0]   nk [0:2*LEAVES-2];
      logic [ID_W-1:0] ni [0:2*LEAVES-2];
      for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
         if (l < N) begin : g_real
            assign nk[LEAVES-1+l] = keys[l*KW +: KW];
            assign ni[LEAVES-1+l] = ID_W'(l);
         end else begin : g_pad
            assign nk[LEAVES-1+l] = {1'b1, {(KW-1){1'b0}}};
            assign ni[LEAVES-1+l] = ID_W'(IDLE_ID);
         end
      end
      for (genvar j = 0; j < LEAVES-1; j++) begin : g_node
         // left child holds lower identifiers; right wins only when strictly smaller
         logic take_r;
         assign take_r = nk[2*j+2] < nk[2*j+1];
         assign nk[j]  = take_r ? nk[2*j+2] : nk[2*j+1];
         assign ni[j]  = take_r ? ni[2*j+2] : ni[2*j+1];
      end
      assign best_key = nk[0];
      assign best_id  = ni[0];
   end else begin : g_scan
      always_comb begin
         best_key = {1'b1, {(KW-1){1'b0}}};
         best_id  = ID_W'(IDLE_ID);
         for (int i = 0; i < N; i++) begin
            if (keys[i*KW +: KW] < best_key) begin
               best_key = keys[i*KW +: KW];
               best_id  = ID_W'(i);
            end
         end
      end
   end
endmodule

// File: rtl/irq_cpu_gate.sv
module irq_cpu_gate
   import irq_arb_pkg::*;
#(
   parameter int PRIO_W = 8,
   localparam int KW    = PRIO_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dist_en,
   input  logic              if_en,
   input  logic [KW-1:0]     best_key,
   input  logic [ID_W-1:0]   best_id,
   input  logic [PRIO_W-1:0] mask,
   input  logic [KW-1:0]     run,
   output logic              irq_q,
   output logic [ID_W-1:0]   id_q
);
   logic live, shown, irq_d;
   logic [ID_W-1:0] id_d;

   assign live  = dist_en && if_en;
   assign shown = live && (best_key <= {1'b0, mask});
   assign irq_d = shown && (best_key < run);
   assign id_d  = shown ? best_id : ID_W'(IDLE_ID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         id_q  <= ID_W'(IDLE_ID);
      end else begin
         irq_q <= irq_d;
         id_q  <= id_d;
      end
   end

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !live |=> (!irq_q && id_q == ID_W'(IDLE_ID))); // R4
   AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      best_key[KW-1] |=> (!irq_q && id_q == ID_W'(IDLE_ID))); // R3
   AST_RUN_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (run == '0) |=> !irq_q); // R6
   AST_IRQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> id_q != ID_W'(IDLE_ID)); // R6
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int NUM_CPU = 2,
   parameter int PRIO_W  = 8,
   parameter bit TREE    = 1'b1,
   localparam int KW     = PRIO_W + 1,
   localparam int SHR_N  = NUM_IRQ - BANKED_N
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           dist_en,
   input  logic [NUM_CPU-1:0]             cpu_if_en,
   input  logic [NUM_CPU*NUM_IRQ-1:0]     line_en,
   input  logic [NUM_CPU*NUM_IRQ-1:0]     line_pend,
   input  logic [NUM_CPU*BANKED_N*PRIO_W-1:0] prio_banked,
   input  logic [SHR_N*PRIO_W-1:0]        prio_shared,
   input  logic [NUM_CPU*PRIO_W-1:0]      prio_mask,
   input  logic [NUM_CPU*KW-1:0]          run_prio,
   output logic [NUM_CPU-1:0]             cpu_irq,
   output logic [NUM_CPU*ID_W-1:0]        hp_id
);
   if (NUM_IRQ % BANKED_N != 0 || NUM_IRQ <= BANKED_N || NUM_IRQ > 1020) begin : g_bad_irq
      $error("NUM_IRQ must be a multiple of 32 in 64..1020");
   end
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must be 1..8");
   end

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [NUM_IRQ*KW-1:0] keys;
      logic [KW-1:0]         bkey;
      logic [ID_W-1:0]       bid;

      irq_cand_build #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_cand (
         .en       (line_en[c*NUM_IRQ +: NUM_IRQ]),
         .pend     (line_pend[c*NUM_IRQ +: NUM_IRQ]),
         .prio_own (prio_banked[c*BANKED_N*PRIO_W +: BANKED_N*PRIO_W]),
         .prio_shr (prio_shared),
         .keys     (keys)
      );

      irq_min_select #(.N(NUM_IRQ), .KW(KW), .TREE(TREE)) u_sel (
         .keys     (keys),
         .best_key (bkey),
         .best_id  (bid)
      );

      irq_cpu_gate #(.PRIO_W(PRIO_W)) u_gate (
         .clk      (clk),
         .rst_n    (rst_n),
         .dist_en  (dist_en),
         .if_en    (cpu_if_en[c]),
         .best_key (bkey),
         .best_id  (bid),
         .mask     (prio_mask[c*PRIO_W +: PRIO_W]),
         .run      (run_prio[c*KW +: KW]),
         .irq_q    (cpu_irq[c]),
         .id_q     (hp_id[c*ID_W +: ID_W])
      );

      AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (hp_id[c*ID_W +: ID_W] == ID_W'(IDLE_ID)) || (hp_id[c*ID_W +: ID_W] < ID_W'(NUM_IRQ))); // R1
      AST_ID_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
         (dist_en && cpu_if_en[c] && bid != ID_W'(IDLE_ID) && bkey <= {1'b0, prio_mask[c*PRIO_W +: PRIO_W]})
         |=> (hp_id[c*ID_W +: ID_W] != ID_W'(IDLE_ID))); // R5
   end
endmodule

// File: tb/tb_irq_prio_arbiter.sv
`timescale 1ns/1ps
module tb_irq_prio_arbiter;
   localparam int NI = 64;
   localparam int NC = 2;
   localparam int PW = 8;
   localparam int BK = 32;

   logic clk = 1'b0;
   logic rst_n;
   logic dist_en;
   logic [NC-1:0]       cpu_if_en;
   logic [NC*NI-1:0]    line_en, line_pend;
   logic [NC*BK*PW-1:0] prio_banked;
   logic [(NI-BK)*PW-1:0] prio_shared;
   logic [NC*PW-1:0]    prio_mask;
   logic [NC*(PW+1)-1:0] run_prio;
   logic [NC-1:0]       cpu_irq;
   logic [NC*10-1:0]    hp_id;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_prio_arbiter #(.NUM_IRQ(NI), .NUM_CPU(NC), .PRIO_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_if_en(cpu_if_en),
      .line_en(line_en), .line_pend(line_pend), .prio_banked(prio_banked),
      .prio_shared(prio_shared), .prio_mask(prio_mask), .run_prio(run_prio),
      .cpu_irq(cpu_irq), .hp_id(hp_id)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model(input int c, output int id, output int irq);
      int best, bid, p;
      best = 256; bid = 1023;
      for (int i = 0; i < NI; i++) begin
         if (line_en[c*NI+i] && line_pend[c*NI+i]) begin
            p = (i < BK) ? int'(prio_banked[(c*BK+i)*PW +: PW]) : int'(prio_shared[(i-BK)*PW +: PW]);
            if (p < best) begin best = p; bid = i; end
         end
      end
      id = 1023; irq = 0;
      if (dist_en && cpu_if_en[c] && best <= int'(prio_mask[c*PW +: PW])) begin
         id = bid;
         irq = (best < int'(run_prio[c*(PW+1) +: PW+1])) ? 1 : 0;
      end
   endtask

   task automatic check_all(input string req);
      int id, irq;
      for (int c = 0; c < NC; c++) begin
         model(c, id, irq);
         chk({req, " id"}, int'(hp_id[c*10 +: 10]), id);
         chk({req, " irq"}, int'(cpu_irq[c]), irq);
      end
   endtask

   task automatic step(input string req);
      @(posedge clk); #1;
      check_all(req);
      @(negedge clk);
   endtask

   task automatic clear_all();
      dist_en = 1; cpu_if_en = '1; line_en = '0; line_pend = '0;
      prio_banked = '0; prio_shared = '0; prio_mask = {NC{8'hFF}};
      run_prio = {NC{9'h100}};
   endtask

   task automatic set_p(input int c, input int i, input int p);
      if (i < BK) prio_banked[(c*BK+i)*PW +: PW] = PW'(p);
      else prio_shared[(i-BK)*PW +: PW] = PW'(p);
   endtask

   task automatic arm(input int c, input int i);
      line_en[c*NI+i] = 1'b1; line_pend[c*NI+i] = 1'b1;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [9:0] hold_id;
      void'($urandom(32'd20240611));
      rst_n = 0;
      clear_all();
      arm(0, 4); arm(1, 4); set_p(0, 4, 1); set_p(1, 4, 1);
      repeat (3) @(posedge clk);
      #1;
      // R9 reset state
      chk("R9 reset irq", int'(cpu_irq), 0);
      chk("R9 reset id0", int'(hp_id[9:0]), 1023);
      chk("R9 reset id1", int'(hp_id[19:10]), 1023);
      @(negedge clk); rst_n = 1;
      step("R1 basic");

      // R3 nothing pending
      clear_all(); step("R3 empty");

      // R2 tie among banked and shared lines
      clear_all();
      arm(0, 7); arm(0, 3); set_p(0, 7, 16); set_p(0, 3, 16);
      arm(1, 50); arm(1, 33); set_p(1, 50, 32); set_p(1, 33, 32);
      step("R2 tie");
      chk("R2 tie cpu0", int'(hp_id[9:0]), 3);
      chk("R2 tie cpu1", int'(hp_id[19:10]), 33);

      // R7 banked vs shared priorities
      clear_all();
      arm(0, 5); arm(1, 5); set_p(0, 5, 8'h10); set_p(1, 5, 8'h80);
      arm(0, 40); arm(1, 40); set_p(0, 40, 8'h40);
      step("R7 banked");
      chk("R7 cpu0", int'(hp_id[9:0]), 5);
      chk("R7 cpu1", int'(hp_id[19:10]), 40);

      // R8 per-cpu enables
      clear_all();
      line_en[1*NI+20] = 1; line_pend[0*NI+20] = 1; line_pend[1*NI+20] = 1;
      step("R8 per-cpu");
      chk("R8 cpu0", int'(hp_id[9:0]), 1023);
      chk("R8 cpu1", int'(hp_id[19:10]), 20);

      // R5 mask boundary
      clear_all();
      arm(0, 9); set_p(0, 9, 8'h60); prio_mask[7:0] = 8'h60;
      step("R5 mask equal");
      chk("R5 equal", int'(hp_id[9:0]), 9);
      prio_mask[7:0] = 8'h5F;
      step("R5 mask below");
      chk("R5 below", int'(hp_id[9:0]), 1023);

      // R6 running priority boundary
      prio_mask[7:0] = 8'hFF; run_prio[8:0] = 9'h060;
      step("R6 run equal");
      chk("R6 equal", int'(cpu_irq[0]), 0);
      run_prio[8:0] = 9'h061;
      step("R6 run above");
      chk("R6 above", int'(cpu_irq[0]), 1);

      // R4 global and per-interface disable
      arm(1, 9);
      cpu_if_en = 2'b10;
      step("R4 if off");
      chk("R4 cpu0 off", int'(hp_id[9:0]), 1023);
      chk("R4 cpu1 on", int'(hp_id[19:10]), 9);
      cpu_if_en = '1; dist_en = 0;
      step("R4 dist off");

      // R9 outputs hold between edges
      dist_en = 1;
      step("R9 setup");
      hold_id = hp_id[9:0];
      line_pend = '0;
      #1;
      chk("R9 hold", int'(hp_id[9:0]), int'(hold_id));
      step("R9 update");

      // R1 random patterns
      for (int n = 0; n < 400; n++) begin
         dist_en = ($urandom % 10) != 0;
         for (int c = 0; c < NC; c++) begin
            cpu_if_en[c] = ($urandom % 10) != 0;
            prio_mask[c*PW +: PW] = ($urandom % 3 == 0) ? PW'($urandom) : 8'hFF;
            run_prio[c*(PW+1) +: PW+1] = ($urandom % 4 == 0) ? 9'h100 : 9'($urandom % 256);
         end
         for (int b = 0; b < NC*NI; b++) begin
            line_en[b]   = ($urandom % 4) != 0;
            line_pend[b] = ($urandom % 5) == 0;
         end
         for (int b = 0; b < NC*BK; b++) prio_banked[b*PW +: PW] = PW'(($urandom % 8) * 32);
         for (int b = 0; b < NI-BK; b++) prio_shared[b*PW +: PW] = PW'(($urandom % 8) * 32);
         step("R1 random");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule